// File: doc/BRIEF.md
# Oldest-Head / Youngest-Tail Thread Selector

This block sits beside a reorder buffer that keeps one in-order queue per hardware thread. Each cycle it looks at every thread's queue boundary. It reports which thread holds the oldest instruction in the machine, which is the global head, and which thread holds the youngest one, which is the global tail. Age is given by the instruction sequence number, and a lower number is older. The queues themselves are kept elsewhere. This block only sees, for each thread, an empty flag, the head and tail sequence numbers, and a head-ready flag. It also receives a mask of the threads that are currently active.

A thread qualifies when it is active and its queue is not empty. The head pick and the tail pick are each made with a full comparison across all qualifying threads. The block also raises a commit-possible flag when at least one qualifying thread has a head entry that is ready to retire. The selection logic is combinational. A parameter places one register stage on the outputs, and it is enabled by default.

Top module: `age_endpoint_sel`

## Requirements
- R1: A thread whose active bit is 0 or whose empty flag is 1 is never reported as the global head or the global tail, whatever its sequence numbers are.
- R2: The global head thread is the qualifying thread with the lowest head sequence number.
- R3: The global tail thread is the qualifying thread with the highest tail sequence number.
- R4: When no thread qualifies, both valid outputs are 0 and both thread-ID outputs are 0.
- R5: `commit_ok` is 1 exactly when some thread that is active and non-empty has its head-ready bit set.
- R6: The head-ready bit of a thread whose empty flag is 1 has no effect on `commit_ok`.
- R7: When two or more qualifying threads share the winning sequence number, the thread with the lowest index wins. This applies to both the head pick and the tail pick.
- R8: Sequence numbers are compared as unsigned values of `SEQ_W` bits. For example, 16'hFFFF is younger than 16'h0001.
- R9: With `REG_OUT`=1, every output reflects the inputs present at the previous rising clock edge. While `rst_n` is 0, all outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| act_mask | input | NTHR | Thread active bits; bit i belongs to thread i |
| q_empty | input | NTHR | Queue empty flags; bit i belongs to thread i |
| hd_ready | input | NTHR | Head entry ready to retire; bit i belongs to thread i |
| hd_seq | input | NTHR*SEQ_W | Head sequence numbers; thread i in bits [i*SEQ_W +: SEQ_W] |
| tl_seq | input | NTHR*SEQ_W | Tail sequence numbers; thread i in bits [i*SEQ_W +: SEQ_W] |
| gh_vld | output | 1 | Global head valid |
| gh_tid | output | TID_W | Thread holding the oldest head |
| gt_vld | output | 1 | Global tail valid |
| gt_tid | output | TID_W | Thread holding the youngest tail |
| commit_ok | output | 1 | Some qualifying thread's head can retire |

## Verification
With the default output register, every result is due one rising edge after the inputs it depends on. The bench changes inputs only on falling edges, and at the same moment it queues the value it expects. A monitor then takes one entry off the queue a quarter period after each following rising edge and compares it, so each expectation is checked in the one cycle where that stimulus is visible. The reset values are checked directly while reset is held, and the queue is empty at that time.

// File: rtl/sel_pkg.sv
package sel_pkg;

    // Direction of an extreme search over sequence numbers
    typedef enum logic {
        PICK_MIN = 1'b0,
        PICK_MAX = 1'b1
    } pick_e;

    // Strict unsigned "better than" test; equality never wins, so the
    // earliest candidate in a scan keeps the slot on a tie.
    function automatic logic beats(input pick_e dir,
                                   input logic [63:0] cand,
                                   input logic [63:0] best);
        if (dir == PICK_MAX) return cand > best;
        else                 return cand < best;
    endfunction

endpackage

// File: rtl/thr_qualify.sv
module thr_qualify #(
    parameter int NTHR = 4
) (
    input  logic [NTHR-1:0] act_mask,
    input  logic [NTHR-1:0] q_empty,
    input  logic [NTHR-1:0] hd_ready,
    output logic [NTHR-1:0] elig,
    output logic            any_ready
);

    logic [NTHR-1:0] rdy_masked;

    always_comb begin
        elig       = act_mask & ~q_empty;
        // an empty queue has no head, so its ready bit is discarded
        rdy_masked = hd_ready & elig;
        any_ready  = |rdy_masked;
    end

endmodule

// File: rtl/seq_extreme.sv
module seq_extreme
    import sel_pkg::*;
#(
    parameter int    NTHR  = 4,
    parameter int    SEQ_W = 16,
    parameter int    TID_W = 2,
    parameter pick_e DIR   = PICK_MIN
) (
    input  logic [NTHR-1:0]       elig,
    input  logic [NTHR*SEQ_W-1:0] seq,
    output logic                  found,
    output logic [TID_W-1:0]      win_tid
);

    logic [SEQ_W-1:0] best;

    always_comb begin
        found   = 1'b0;
        win_tid = '0;
        best    = '0;
        for (int i = 0; i < NTHR; i++) begin
            if (elig[i]) begin
                if (!found || beats(DIR, 64'(seq[i*SEQ_W +: SEQ_W]), 64'(best))) begin
                    found   = 1'b1;
                    win_tid = TID_W'(i);
                    best    = seq[i*SEQ_W +: SEQ_W];
                end
            end
        end
    end

endmodule

// File: rtl/age_endpoint_sel.sv
module age_endpoint_sel
    import sel_pkg::*;
#(
    parameter int NTHR    = 4,
    parameter int SEQ_W   = 16,
    parameter bit REG_OUT = 1'b1,
    localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTHR-1:0]       act_mask,
    input  logic [NTHR-1:0]       q_empty,
    input  logic [NTHR-1:0]       hd_ready,
    input  logic [NTHR*SEQ_W-1:0] hd_seq,
    input  logic [NTHR*SEQ_W-1:0] tl_seq,
    output logic                  gh_vld,
    output logic [TID_W-1:0]      gh_tid,
    output logic                  gt_vld,
    output logic [TID_W-1:0]      gt_tid,
    output logic                  commit_ok
);

    typedef struct packed {
        logic             h_vld;
        logic [TID_W-1:0] h_tid;
        logic             t_vld;
        logic [TID_W-1:0] t_tid;
        logic             commit;
    } res_t;

    logic [NTHR-1:0]  elig;
    logic             any_ready;
    logic             h_found, t_found;
    logic [TID_W-1:0] h_win, t_win;
    res_t             res_d, res_q;

    thr_qualify #(.NTHR(NTHR)) u_qual (
        .act_mask (act_mask),
        .q_empty  (q_empty),
        .hd_ready (hd_ready),
        .elig     (elig),
        .any_ready(any_ready)
    );

    seq_extreme #(.NTHR(NTHR), .SEQ_W(SEQ_W), .TID_W(TID_W), .DIR(PICK_MIN)) u_head (
        .elig   (elig),
        .seq    (hd_seq),
        .found  (h_found),
        .win_tid(h_win)
    );

    seq_extreme #(.NTHR(NTHR), .SEQ_W(SEQ_W), .TID_W(TID_W), .DIR(PICK_MAX)) u_tail (
        .elig   (elig),
        .seq    (tl_seq),
        .found  (t_found),
        .win_tid(t_win)
    );

    always_comb begin
        res_d        = '0;
        res_d.h_vld  = h_found;
        res_d.h_tid  = h_found ? h_win : '0;
        res_d.t_vld  = t_found;
        res_d.t_tid  = t_found ? t_win : '0;
        res_d.commit = any_ready;
    end

    generate
        if (REG_OUT) begin : g_reg
            logic armed_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q   <= '0;
                    armed_q <= 1'b0;
                end else begin
                    res_q   <= res_d;
                    armed_q <= 1'b1;
                end
            end

            // R9
            out_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                armed_q |-> ({gh_vld, gh_tid, gt_vld, gt_tid, commit_ok} == $past(res_d)));
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign gh_vld    = res_q.h_vld;
    assign gh_tid    = res_q.h_tid;
    assign gt_vld    = res_q.t_vld;
    assign gt_tid    = res_q.t_tid;
    assign commit_ok = res_q.commit;

    // R1
    head_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_found |-> (act_mask[h_win] && !q_empty[h_win]));

    // R1
    tail_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_found |-> (act_mask[t_win] && !q_empty[t_win]));

    // R4
    none_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_mask & ~q_empty) == '0) |-> (!res_d.h_vld && !res_d.t_vld && !res_d.commit));

    // R5
    commit_has_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_ready |-> h_found);

endmodule

// File: tb/sim_age_endpoint_sel.sv
module sim_age_endpoint_sel;

    localparam int CLK_P = 10;
    localparam int NT    = 4;
    localparam int SW    = 16;

    typedef struct {
        string      tag;
        logic       hv;
        logic [1:0] ht;
        logic       tv;
        logic [1:0] tt;
        logic       c;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NT-1:0]    act_mask = '0, q_empty = '0, hd_ready = '0;
    logic [NT*SW-1:0] hd_seq = '0, tl_seq = '0;
    logic             gh_vld, gt_vld, commit_ok;
    logic [1:0]       gh_tid, gt_tid;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    age_endpoint_sel #(.NTHR(NT), .SEQ_W(SW), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .act_mask(act_mask), .q_empty(q_empty), .hd_ready(hd_ready),
        .hd_seq(hd_seq), .tl_seq(tl_seq),
        .gh_vld(gh_vld), .gh_tid(gh_tid),
        .gt_vld(gt_vld), .gt_tid(gt_tid),
        .commit_ok(commit_ok)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got hv=%0b ht=%0d tv=%0b tt=%0d c=%0b, expected hv=%0b ht=%0d tv=%0b tt=%0d c=%0b",
                     tag, act[6], act[5:4], act[3], act[2:1], act[0],
                     expv[6], expv[5:4], expv[3], expv[2:1], expv[0]);
        end
    endtask

    // driver: applies one input set and queues its expected result
    task automatic drive(input string tag, input logic [3:0] a, input logic [3:0] e,
                         input logic [3:0] r, input logic [63:0] hs, input logic [63:0] ts);
        exp_t x;
        logic [15:0] bh, bt;
        @(negedge clk);
        act_mask = a; q_empty = e; hd_ready = r; hd_seq = hs; tl_seq = ts;
        x.tag = tag; x.hv = 0; x.ht = 0; x.tv = 0; x.tt = 0; x.c = 0;
        bh = '0; bt = '0;
        for (int i = 0; i < NT; i++) begin
            if (a[i] && !e[i]) begin
                if (!x.hv || hs[i*16 +: 16] < bh) begin x.hv = 1; x.ht = 2'(i); bh = hs[i*16 +: 16]; end
                if (!x.tv || ts[i*16 +: 16] > bt) begin x.tv = 1; x.tt = 2'(i); bt = ts[i*16 +: 16]; end
                if (r[i]) x.c = 1;
            end
        end
        sb.push_back(x);
    endtask

    // monitor: compares one queued expectation per cycle
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            check(x.tag, {1'b0, gh_vld, gh_tid, gt_vld, gt_tid, commit_ok},
                  {1'b0, x.hv, x.ht, x.tv, x.tt, x.c});
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R9: outputs held at zero in reset even with qualifying inputs
        act_mask = 4'hF; hd_ready = 4'hF;
        hd_seq = {16'd4, 16'd3, 16'd2, 16'd1}; tl_seq = hd_seq;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check("R9 reset", {1'b0, gh_vld, gh_tid, gt_vld, gt_tid, commit_ok}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: nothing active
        drive("R4 none active", 4'h0, 4'h0, 4'hF, {16'd1, 16'd2, 16'd3, 16'd4}, {16'd9, 16'd9, 16'd9, 16'd9});
        // R2 R3: distinct numbers (thread 3 in top slice)
        drive("R2 R3 distinct", 4'hF, 4'h0, 4'h0, {16'd20, 16'd30, 16'd10, 16'd40}, {16'd60, 16'd70, 16'd12, 16'd95});
        // R1: oldest head and youngest tail on an inactive thread
        drive("R1 inactive", 4'b1101, 4'h0, 4'h0, {16'd20, 16'd30, 16'd10, 16'd40}, {16'd60, 16'd70, 16'd200, 16'd95});
        // R1: extreme values on an empty thread
        drive("R1 empty", 4'hF, 4'b0001, 4'h0, {16'd20, 16'd30, 16'd10, 16'd1}, {16'd60, 16'd70, 16'd12, 16'd999});
        // R7: all tied
        drive("R7 tie all", 4'hF, 4'h0, 4'h0, {16'd5, 16'd5, 16'd5, 16'd5}, {16'd5, 16'd5, 16'd5, 16'd5});
        // R7: tie with thread 0 inactive
        drive("R7 tie skip0", 4'b1110, 4'h0, 4'h0, {16'd5, 16'd5, 16'd5, 16'd5}, {16'd5, 16'd5, 16'd5, 16'd5});
        // R8: unsigned ordering around the top bit
        drive("R8 unsigned", 4'hF, 4'h0, 4'h0, {16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF}, {16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF});
        // R5: ready on an active non-empty thread
        drive("R5 ready", 4'hF, 4'h0, 4'b0100, {16'd4, 16'd3, 16'd2, 16'd1}, {16'd8, 16'd7, 16'd6, 16'd5});
        // R5: ready only on an inactive thread
        drive("R5 ready inactive", 4'b1011, 4'h0, 4'b0100, {16'd4, 16'd3, 16'd2, 16'd1}, {16'd8, 16'd7, 16'd6, 16'd5});
        // R6: ready only on an empty thread
        drive("R6 ready empty", 4'hF, 4'b0010, 4'b0010, {16'd4, 16'd3, 16'd2, 16'd1}, {16'd8, 16'd7, 16'd6, 16'd5});
        // R4: all active but all empty
        drive("R4 all empty", 4'hF, 4'hF, 4'hF, {16'd4, 16'd3, 16'd2, 16'd1}, {16'd8, 16'd7, 16'd6, 16'd5});
        // R2 R3: single qualifier is thread 3
        drive("R2 R3 single", 4'b1000, 4'h0, 4'b1000, {16'd400, 16'd3, 16'd2, 16'd1}, {16'd1, 16'd7, 16'd6, 16'd5});
        // R9: back-to-back changes, one per cycle
        drive("R9 step a", 4'hF, 4'h0, 4'h1, {16'd1, 16'd2, 16'd3, 16'd4}, {16'd9, 16'd8, 16'd7, 16'd6});
        drive("R9 step b", 4'hF, 4'h0, 4'h0, {16'd4, 16'd3, 16'd1, 16'd2}, {16'd6, 16'd9, 16'd7, 16'd8});
        drive("R9 step c", 4'h0, 4'h0, 4'h0, {16'd4, 16'd3, 16'd1, 16'd2}, {16'd6, 16'd9, 16'd7, 16'd8});

        repeat (4) @(posedge clk);
        #(CLK_P/2);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule